// File: doc/BRIEF.md
# Hybrid Selective-Harmonic PWM Sequencer

This block drives the three legs of a three-level neutral-point-clamped inverter with level codes for positive, zero and negative output. Each leg waveform is rebuilt every fundamental cycle from a short table of precomputed switching angles. The angles cover one quarter cycle, and the other three quarters follow by mirroring and sign inversion. A phase accumulator advanced by a frequency word sets the fundamental. Legs b and c run the same pattern one third and two thirds of a cycle behind leg a.

Two angle tables are held. The conventional table keeps triplen harmonics in each leg and reaches the higher modulation index needed near rated speed. The modified table cancels the low-order triplens, which lowers the common-mode voltage at reduced speed. The block compares the frequency word with a programmable floor to choose the table. A change of choice waits for the end of the running fundamental cycle and takes effect only at the next zero crossing. Angles are written through a small write port, and the port only accepts writes to the table that is not driving the legs.

Top module: `hshe_pwm_seq`

## Requirements
- R1: Each leg code is 2'b01 for +1, 2'b00 for 0 and 2'b11 for -1. The code 2'b10 never appears.
- R2: A 32-bit phase accumulator is zero after reset. It adds `step_word` on every clock, modulo 2^32.
- R3: Leg a takes its quadrant from phase bits [31:30] and its offset from bits [29:14]. The position is the offset in quadrants 0 and 2 and its bitwise complement in quadrants 1 and 3. The leg is nonzero when an odd number of the 9 active angles are strictly less than the position.
- R4: A nonzero leg is +1 while phase bit 31 is 0 and -1 while it is 1.
- R5: Leg b applies the R3/R4 rule to the phase minus 1431655765, and leg c to the phase minus 2863311531, both modulo 2^32.
- R6: The conventional table is wanted when `step_word` >= `conv_floor`. Otherwise the modified table is wanted. `conv_active` is 1 while the conventional table drives the legs.
- R7: The active table and `conv_active` change only on a clock edge where the accumulator addition wraps past 2^32-1. On that edge they take the wanted table from R6, and the legs use the new table from the first wrapped phase onwards.
- R8: A write (`wr_en`, with `wr_conv` 1 selecting the conventional table and 0 the modified table) stores `wr_angle` at entry `wr_idx` only when the selected table is inactive and `wr_idx` < 9. A write to the active table stores nothing and sets `wr_fault`. `wr_fault` stays set until reset. An index of 9 or more is dropped silently.
- R9: After reset all legs read 0, `conv_active` is 1, `wr_fault` is 0 and every angle in both tables is 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_word | input | 32 | Phase increment per clock |
| conv_floor | input | 32 | Lowest step_word that selects the conventional table |
| wr_en | input | 1 | Angle write strobe |
| wr_conv | input | 1 | Write target: 1 conventional, 0 modified |
| wr_idx | input | 4 | Angle entry index |
| wr_angle | input | 16 | Angle as a fraction of a quarter cycle |
| leg_a | output | 2 | Leg a level code |
| leg_b | output | 2 | Leg b level code |
| leg_c | output | 2 | Leg c level code |
| conv_active | output | 1 | Conventional table in use |
| wr_fault | output | 1 | Sticky flag for a write aimed at the active table |

## Verification
The hardest cases to reach are those where the wanted table and the accumulator wrap interact. One is a wanted-table change that reverts before any wrap. Another is a step word exactly equal to the floor. A third is an angle write that lands on the same edge as a switchover. The stimulus moves `step_word` across the floor at arbitrary points of a fundamental cycle and holds it there for a few cycles at a time. It also loads each table only after the other has become active. A behavioural phase model in the bench follows the wrap edges and scores every leg and both flags on every clock.

// File: rtl/hshe_pwm_seq.sv
module hshe_pwm_seq #(
  parameter int PH_W  = 32,
  parameter int ANG_W = 16,
  parameter int NANG  = 9,
  parameter int IDX_W = $clog2(NANG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  step_word,
  input  logic [PH_W-1:0]  conv_floor,
  input  logic             wr_en,
  input  logic             wr_conv,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ANG_W-1:0] wr_angle,
  output logic [1:0]       leg_a,
  output logic [1:0]       leg_b,
  output logic [1:0]       leg_c,
  output logic             conv_active,
  output logic             wr_fault
);

  localparam logic [PH_W-1:0] SHIFT_120 = PH_W'((64'd1 << PH_W) / 3);
  localparam logic [PH_W-1:0] SHIFT_240 = PH_W'(((64'd1 << PH_W) * 2 + 1) / 3);

  typedef logic [NANG-1:0][ANG_W-1:0] angset_t;

  logic [PH_W-1:0] acc;
  logic [PH_W-1:0] acc_nx;
  logic            wrap;
  logic            conv_q;
  logic            fault_q;
  angset_t         tbl [2];

  assign {wrap, acc_nx} = {1'b0, acc} + {1'b0, step_word};

  function automatic logic [1:0] leg_code(input logic [PH_W-1:0] ph, input angset_t a);
    logic [ANG_W-1:0] pos;
    logic             odd;
    pos = ph[PH_W-2] ? ~ph[PH_W-3 -: ANG_W] : ph[PH_W-3 -: ANG_W];
    odd = 1'b0;
    for (int i = 0; i < NANG; i++)
      odd = odd ^ (a[i] < pos);
    return odd ? (ph[PH_W-1] ? 2'b11 : 2'b01) : 2'b00;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      conv_q  <= 1'b1;
      fault_q <= 1'b0;
      tbl[0]  <= '1;
      tbl[1]  <= '1;
    end else begin
      acc <= acc_nx;
      if (wrap)
        conv_q <= (step_word >= conv_floor);
      if (wr_en) begin
        if (wr_conv == conv_q)
          fault_q <= 1'b1;
        else if (wr_idx < IDX_W'(NANG))
          tbl[wr_conv][wr_idx] <= wr_angle;
      end
    end
  end

  assign leg_a       = leg_code(acc, tbl[conv_q]);
  assign leg_b       = leg_code(acc - SHIFT_120, tbl[conv_q]);
  assign leg_c       = leg_code(acc - SHIFT_240, tbl[conv_q]);
  assign conv_active = conv_q;
  assign wr_fault    = fault_q;

  a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_a != 2'b10) && (leg_b != 2'b10) && (leg_c != 2'b10));

  a_r4_sign_by_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc[PH_W-1] |-> leg_a != 2'b11));

  a_r7_switch_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_q != $past(conv_q)) |-> (acc < $past(acc)));

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_q) |-> fault_q);

  a_r8_fault_on_active_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_conv == conv_q)) |=> fault_q);

  a_r8_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_q == $past(conv_q)) |-> (tbl[conv_q] == $past(tbl[conv_q])));

endmodule

// File: tb/hshe_pwm_seq_test.sv
module hshe_pwm_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] step_word = '0;
  logic [31:0] conv_floor = '0;
  logic        wr_en = 1'b0;
  logic        wr_conv = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [15:0] wr_angle = '0;
  logic [1:0]  leg_a, leg_b, leg_c;
  logic        conv_active, wr_fault;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  longint m_acc;
  int     m_conv;
  int     m_err;
  int     m_tbl [2][9];

  always #4 clk = ~clk;

  hshe_pwm_seq uut (
    .clk(clk), .rst_n(rst_n), .step_word(step_word), .conv_floor(conv_floor),
    .wr_en(wr_en), .wr_conv(wr_conv), .wr_idx(wr_idx), .wr_angle(wr_angle),
    .leg_a(leg_a), .leg_b(leg_b), .leg_c(leg_c),
    .conv_active(conv_active), .wr_fault(wr_fault)
  );

  function automatic logic [1:0] exp_leg(longint ph);
    longint p = ph % 64'd4294967296;
    int quad = int'(p / 64'd1073741824);
    int off  = int'((p / 64'd16384) % 64'd65536);
    int pos  = (quad % 2 == 1) ? 65535 - off : off;
    int n = 0;
    for (int k = 0; k < 9; k++)
      if (m_tbl[m_conv][k] < pos) n++;
    if (n % 2 == 0) return 2'b00;
    return (quad >= 2) ? 2'b11 : 2'b01;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_conv = 1; m_err = 0;
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 9; k++) m_tbl[s][k] = 65535;
  endtask

  task automatic compare_all();
    chk("R2/R3 leg_a", {30'd0, leg_a}, {30'd0, exp_leg(m_acc)});
    chk("R5 leg_b", {30'd0, leg_b}, {30'd0, exp_leg(m_acc + 64'd4294967296 - 64'd1431655765)});
    chk("R5 leg_c", {30'd0, leg_c}, {30'd0, exp_leg(m_acc + 64'd4294967296 - 64'd2863311531)});
    chk("R6/R7 conv_active", {31'd0, conv_active}, m_conv[31:0]);
    chk("R8 wr_fault", {31'd0, wr_fault}, m_err[31:0]);
    chk("R1 code legal", {31'd0, (leg_a == 2'b10) || (leg_b == 2'b10) || (leg_c == 2'b10)}, 32'd0);
  endtask

  task automatic tick();
    longint sum;
    @(posedge clk);
    if (rst_n) begin
      sum = m_acc + longint'(step_word);
      if (wr_en) begin
        if (int'(wr_conv) == m_conv) m_err = 1;
        else if (wr_idx < 9) m_tbl[wr_conv][wr_idx] = int'(wr_angle);
      end
      if (sum >= 64'd4294967296) m_conv = (step_word >= conv_floor) ? 1 : 0;
      m_acc = sum % 64'd4294967296;
    end else begin
      model_reset();
    end
    #2;
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(bit conv, int idx, int val);
    wr_en = 1'b1; wr_conv = conv; wr_idx = idx[3:0]; wr_angle = val[15:0];
    tick();
    wr_en = 1'b0;
  endtask

  task automatic reset_check();
    chk("R9 leg_a", {30'd0, leg_a}, 32'd0);
    chk("R9 leg_b", {30'd0, leg_b}, 32'd0);
    chk("R9 leg_c", {30'd0, leg_c}, 32'd0);
    chk("R9 conv_active", {31'd0, conv_active}, 32'd1);
    chk("R9 wr_fault", {31'd0, wr_fault}, 32'd0);
  endtask

  initial begin
    model_reset();
    rst_n = 1'b0;
    run(4);
    reset_check();
    step_word = 32'h0100_0000;
    conv_floor = 32'h00E0_0000;
    rst_n = 1'b1;
    run(300);
    for (int k = 0; k < 9; k++) wr(1'b0, k, 3000 + k * 7000);
    wr(1'b1, 2, 100);
    wr(1'b0, 12, 5);
    run(100);
    step_word = 32'h00C0_0000;
    run(800);
    for (int k = 0; k < 9; k++) wr(1'b1, k, 2000 + k * 6500);
    wr(1'b0, 4, 10);
    run(100);
    step_word = 32'h00E0_0000;
    run(700);
    step_word = 32'h00D0_0000;
    run(30);
    step_word = 32'h0100_0000;
    run(600);
    step_word = 32'h4000_0001;
    run(200);
    step_word = 32'h0080_0000;
    run(1200);
    rst_n = 1'b0;
    run(2);
    reset_check();
    rst_n = 1'b1;
    run(20);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule